// File: doc/BRIEF.md
# Sensor-Driven Two-Road Signal Controller

This block runs the lights at a crossing of a busy major road and a quieter minor road. A vehicle sensor on the minor road is sampled on every clock. By default the major road has green and the minor road has red. When a vehicle is detected, the controller hands green to the minor road on the next clock edge. In the same cycle it raises a one-cycle request to start the crossing timer.

The timer is a small down-counter inside the block, and its cycle count is set by a parameter. The request loads the timer. The timer counts down once per clock and produces a one-cycle expiry pulse when it reaches zero. The only thing that gives green back to the major road is that pulse. The minor-road sensor has no effect while the minor road has green. The timer request is a Mealy output: it follows the sensor input combinationally within the major-green cycle. The four lamp outputs are decoded from the single state bit alone.

Top module: `road_signal_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the major-green phase and idles the timer. `timer_done` is 0 in the cycle after any clock edge at which `rst` was high, even if reset arrives during the minor-green phase.
- R2: In the major-green phase the lamps are `major_green`=1, `major_red`=0, `minor_green`=0, `minor_red`=1. In the minor-green phase all four values are inverted.
- R3: In the major-green phase with `car_sense`=0, the phase does not change at the next edge.
- R4: In the major-green phase with `car_sense`=1, the next edge enters the minor-green phase.
- R5: `timer_start` equals 1 exactly when the phase is major-green and `car_sense` is 1, in that same cycle. It is 0 in the minor-green phase whatever `car_sense` is.
- R6: In the minor-green phase `car_sense` has no effect: the phase stays until `timer_done` is 1.
- R7: The timer loads `LOAD_CYCLES` at the edge that ends a `timer_start` cycle. `timer_done` is then high for exactly one cycle, the (`LOAD_CYCLES`+1)-th cycle after that edge, so the minor-green phase lasts `LOAD_CYCLES`+1 cycles. A request that arrives while the timer runs reloads it.
- R8: A cycle in the minor-green phase with `timer_done`=1 is followed by the major-green phase at the next edge.
- R9: `major_green` and `minor_green` are never both 1 in the same cycle.
- R10: `timer_done` stays 0 throughout the major-green phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| car_sense | input | 1 | Minor-road vehicle sensor, must be valid at the start of the cycle |
| timer_start | output | 1 | Mealy request that loads the crossing timer |
| timer_done | output | 1 | One-cycle timer expiry pulse |
| major_green | output | 1 | Major-road green lamp |
| major_red | output | 1 | Major-road red lamp |
| minor_green | output | 1 | Minor-road green lamp |
| minor_red | output | 1 | Minor-road red lamp |

## Verification
Two situations are hard to reach from the pins.

The first is a sensor pulse that lands in the same cycle as the expiry pulse. The bench gets there by sweeping several sensor patterns across every cycle of the minor-green window, including a pattern that raises the sensor only in the expiry cycle. It then confirms that the block still returns to major-green and only asks for a fresh timer in the major-green cycle that follows.

The second is a timer left half-run. Reset is applied partway through a minor-green window. The sensor is then held low for longer than a full count, and the bench confirms that no stray expiry pulse appears.

// File: rtl/road_sig_pkg.sv
`timescale 1ns/1ps
package road_sig_pkg;

    // Single state bit: 0 gives the major road green
    typedef enum logic {
        PH_MAJOR_GO = 1'b0,
        PH_MINOR_GO = 1'b1
    } phase_e;

    typedef struct packed {
        logic major_go;
        logic major_stop;
        logic minor_go;
        logic minor_stop;
    } lamp_t;

    // Next phase from present phase, sensor and timer expiry
    function automatic phase_e phase_next(input phase_e cur,
                                          input logic   car,
                                          input logic   expired);
        phase_e nxt;
        nxt = cur;
        case (cur)
            PH_MAJOR_GO: if (car)     nxt = PH_MINOR_GO;
            PH_MINOR_GO: if (expired) nxt = PH_MAJOR_GO;
            default:                  nxt = PH_MAJOR_GO;
        endcase
        return nxt;
    endfunction

    // Mealy request: only while the major road is green and a car waits
    function automatic logic start_req(input phase_e cur, input logic car);
        return (cur == PH_MAJOR_GO) && car;
    endfunction

    function automatic lamp_t lamps_for(input phase_e cur);
        lamp_t l;
        l.major_go   = (cur == PH_MAJOR_GO);
        l.major_stop = (cur == PH_MINOR_GO);
        l.minor_go   = (cur == PH_MINOR_GO);
        l.minor_stop = (cur == PH_MAJOR_GO);
        return l;
    endfunction

endpackage

// File: rtl/phase_fsm.sv
`timescale 1ns/1ps
module phase_fsm
    import road_sig_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car,
    input  logic   expired,
    output phase_e phase,
    output logic   start
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_MAJOR_GO;
        else     phase_q <= phase_next(phase_q, car, expired);
    end

    assign phase = phase_q;
    assign start = start_req(phase_q, car);
endmodule

// File: rtl/countdown_timer.sv
`timescale 1ns/1ps
module countdown_timer #(
    parameter int LOAD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (LOAD_CYCLES < 1) ? 1 : $clog2(LOAD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(LOAD_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            // A request always (re)loads, even while running
            run_q <= 1'b1;
            cnt_q <= LOAD_V;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/lamp_decode.sv
`timescale 1ns/1ps
module lamp_decode
    import road_sig_pkg::*;
(
    input  phase_e phase,
    output lamp_t  lamps
);
    assign lamps = lamps_for(phase);
endmodule

// File: rtl/road_signal_ctrl.sv
`timescale 1ns/1ps
module road_signal_ctrl
    import road_sig_pkg::*;
#(
    parameter int LOAD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic car_sense,
    output logic timer_start,
    output logic timer_done,
    output logic major_green,
    output logic major_red,
    output logic minor_green,
    output logic minor_red
);
    phase_e phase;
    lamp_t  lamps;
    logic   start_w;
    logic   done_w;

    phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .car     (car_sense),
        .expired (done_w),
        .phase   (phase),
        .start   (start_w)
    );

    countdown_timer #(.LOAD_CYCLES(LOAD_CYCLES)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (start_w),
        .expired (done_w)
    );

    lamp_decode u_lamp (
        .phase (phase),
        .lamps (lamps)
    );

    assign timer_start = start_w;
    assign timer_done  = done_w;
    assign major_green = lamps.major_go;
    assign major_red   = lamps.major_stop;
    assign minor_green = lamps.minor_go;
    assign minor_red   = lamps.minor_stop;
endmodule

// File: rtl/road_signal_ctrl_chk.sv
`timescale 1ns/1ps
module road_signal_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic car_sense,
    input logic timer_start,
    input logic timer_done,
    input logic major_green,
    input logic major_red,
    input logic minor_green,
    input logic minor_red
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (major_green && !timer_done));

    assert_major_lamps_R2: assert property (@(posedge clk) disable iff (rst)
        major_green |-> (minor_red && !major_red && !minor_green));

    assert_hold_major_R3: assert property (@(posedge clk) disable iff (rst)
        (major_green && !car_sense) |=> major_green);

    assert_enter_minor_R4: assert property (@(posedge clk) disable iff (rst)
        (major_green && car_sense) |=> minor_green);

    assert_start_mealy_R5: assert property (@(posedge clk) disable iff (rst)
        timer_start == (major_green && car_sense));

    assert_stay_minor_R6: assert property (@(posedge clk) disable iff (rst)
        (minor_green && !timer_done) |=> minor_green);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        timer_done |=> !timer_done);

    assert_return_major_R8: assert property (@(posedge clk) disable iff (rst)
        (minor_green && timer_done) |=> major_green);

    assert_no_double_green_R9: assert property (@(posedge clk) disable iff (rst)
        !(major_green && minor_green));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        major_green |-> !timer_done);
endmodule

bind road_signal_ctrl road_signal_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .car_sense   (car_sense),
    .timer_start (timer_start),
    .timer_done  (timer_done),
    .major_green (major_green),
    .major_red   (major_red),
    .minor_green (minor_green),
    .minor_red   (minor_red)
);

// File: tb/road_signal_ctrl_tb_top.sv
`timescale 1ns/1ps
module road_signal_ctrl_tb_top;
    localparam int N = 5;
    localparam logic [3:0] MAJ = 4'b1001; // {mg, mr, ng, nr}
    localparam logic [3:0] MIN = 4'b0110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car = 1'b0;
    logic timer_start, timer_done;
    logic major_green, major_red, minor_green, minor_red;
    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    road_signal_ctrl #(.LOAD_CYCLES(N)) dut_i (
        .clk(clk), .rst(rst), .car_sense(car),
        .timer_start(timer_start), .timer_done(timer_done),
        .major_green(major_green), .major_red(major_red),
        .minor_green(minor_green), .minor_red(minor_red)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] lamps();
        return {major_green, major_red, minor_green, minor_red};
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        chk("R1", "lamps after reset", lamps(), MAJ);
        chk("R1", "done after reset", timer_done, 1'b0);
        rst = 1'b0;

        for (int wait_c = 0; wait_c < 4; wait_c++) begin
            for (int pat = 0; pat < 4; pat++) begin
                car = 1'b0;
                for (int w = 0; w < wait_c; w++) begin
                    #0.5;
                    chk("R5", "start idle", timer_start, 1'b0);
                    chk("R10", "done in major", timer_done, 1'b0);
                    tick();
                    chk("R3", "hold major", lamps(), MAJ);
                end
                car = 1'b1;
                #0.5;
                chk("R5", "start with car", timer_start, 1'b1);
                chk("R2", "major lamps", lamps(), MAJ);
                tick();
                chk("R4", "entered minor", lamps(), MIN);
                for (int k = 1; k <= N + 1; k++) begin
                    case (pat)
                        0: car = 1'b0;
                        1: car = 1'b1;
                        2: car = k[0];
                        default: car = (k == N + 1);
                    endcase
                    #0.5;
                    chk("R2", "minor lamps", lamps(), MIN);
                    chk("R9", "single green", major_green & minor_green, 1'b0);
                    chk("R5", "no start in minor", timer_start, 1'b0);
                    chk("R7", "expiry timing", timer_done, (k == N + 1));
                    tick();
                    if (k < N + 1) chk("R6", "car ignored in minor", lamps(), MIN);
                end
                car = 1'b0;
                chk("R8", "back to major", lamps(), MAJ);
                chk("R10", "done cleared", timer_done, 1'b0);
                if (pat == 3) begin
                    car = 1'b1;
                    #0.5;
                    chk("R5", "start right after return", timer_start, 1'b1);
                    car = 1'b0;
                    #0.5;
                end
            end
        end

        // Reset partway through a minor window
        car = 1'b1;
        tick();
        car = 1'b0;
        chk("R4", "minor before reset", lamps(), MIN);
        tick(); tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1", "reset mid-minor lamps", lamps(), MAJ);
        chk("R1", "reset mid-minor done", timer_done, 1'b0);
        for (int w = 0; w < N + 3; w++) begin
            tick();
            chk("R10", "timer cleared by reset", timer_done, 1'b0);
            chk("R3", "stays major", lamps(), MAJ);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule